// File: doc/BRIEF.md
# Prescaled Timer and Event Counter with Frequency Divider Output

This block is an up-counter for a microcontroller-class subsystem. It can count prescaled system clocks, count transitions on an external input, or measure the length of one pulse on that input. A preload register supplies the value the counter restarts from after it passes its maximum. Each such overflow sets a sticky interrupt flag and flips a divider flip-flop. That flip-flop can be driven onto a pin as a square wave at half the overflow rate.

Software writes a single control byte and the preload value through simple write strobes. The external input is asynchronous and passes through a synchronizer before any mode uses it. In pulse-measurement mode the block stops itself when the pulse ends. The measured count then stays in the counter until software writes a new preload or restarts the block.

Top module: `evt_timer`

## Requirements
- R1: After reset the count, the preload, the control byte, the overflow flag and the divider output are all zero.
- R2: The control byte holds the mode in bits 1:0 (00 idle, 01 event, 10 timer, 11 pulse), the active polarity in bit 2, the run bit in bit 3, the prescale select in bits 6:4 and the divider pin enable in bit 7. In timer mode the count advances once every 2^(s+1) clocks, where s is the select value and any select of 6 or more gives a divide by 128. The prescaler runs freely from reset, so any window of 128·k consecutive clocks advances the count by exactly k·128/2^(s+1).
- R3: When an increment occurs at count 0xFF, the counter takes the preload value instead of wrapping to zero, and the overflow flag is set on that same clock edge.
- R4: A preload write while the run bit is 0 also loads the counter. A preload write while the run bit is 1 changes only the preload.
- R5: The overflow flag stays set until flag_clr is asserted. If an overflow and a clear fall on the same clock edge, the flag ends up set.
- R6: In event mode the input passes through a two-flop synchronizer. The count advances once for each active transition: rising when polarity is 0, falling when polarity is 1. The counter changes on the third clock edge after the input changes, and the prescaler plays no part.
- R7: In pulse mode the count advances on prescaled ticks while the synchronized input is at its active level (high when polarity is 0, low when it is 1). When the input returns to the inactive level, the run bit clears itself. Later pulses leave the count unchanged. A control write on the same edge takes priority over this automatic clear.
- R8: A divider flip-flop flips on every overflow. The output pin presents it, registered one clock later, only while bit 7 is 1 (and the PFD_OPTION parameter is nonzero); otherwise the pin is 0.
- R9: With the run bit 0, or in idle mode, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| pre_we | input | 1 | Preload write strobe |
| pre_wdata | input | CNT_W | Preload value |
| flag_clr | input | 1 | Clears the overflow flag |
| tmr_in | input | 1 | Asynchronous external event / pulse input |
| count_o | output | CNT_W | Current counter value |
| run_o | output | 1 | Current run bit |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| pfd_o | output | 1 | Divider output pin |

## Verification
Every cycle, the checker confirms several invariants. The count may only step by one, reload after 0xFF, or be written. A reload always comes with the flag. The flag holds until cleared. The divider pin is high only when the enable bit was set, and the run bit clears itself only in pulse mode. Other behaviours need the bench's scenarios against its reference model: the exact prescale periods including the clamp at 128, the three-edge latency of the synchronized input, the edge selection by polarity, and the one-pulse stop with its result held against a second pulse. The same applies to the preload landing in the counter only when stopped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      pfd_en;
    logic [2:0] psel;
    logic      run;
    logic      pol;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int STAGES = 7,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(STAGES - 1);

  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] mask;
  logic [SEL_W-1:0]  sel_c;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    sel_c = (sel >= SEL_MAX) ? SEL_MAX : sel;
    mask  = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (i <= int'(sel_c)) mask[i] = 1'b1;
    end
    tick = &(div_q | ~mask);
  end
endmodule

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic pol,
  output logic act_now,
  output logic act_prev,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sh;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sh[SYNC_STAGES-1];
  end

  assign act_now  = sh[SYNC_STAGES-1] ^ pol;
  assign act_prev = last_q ^ pol;
  assign edge_hit = act_now & ~act_prev;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stopped,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = &cnt_q;
  assign wrap   = inc & at_top;
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_we) pre_q <= load_val;
      if (load_we && stopped) cnt_q <= load_val;
      else if (inc)           cnt_q <= at_top ? pre_q : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_pfd.sv
module tmr_pfd #(
  parameter int ENABLE = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic en,
  output logic pin
);
  localparam logic OPT = (ENABLE != 0);

  logic tgl_q;
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      if (wrap) tgl_q <= ~tgl_q;
      pin_q <= OPT & en & tgl_q;
    end
  end

  assign pin = pin_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_STAGES  = 7,
  parameter int SYNC_STAGES = 2,
  parameter int PFD_OPTION  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_wdata,
  input  logic             flag_clr,
  input  logic             tmr_in,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             ovf_flag_o,
  output logic             pfd_o
);
  localparam int SEL_W = 3;

  tmr_ctl_t ctl_q;
  logic     tick;
  logic     act_now;
  logic     act_prev;
  logic     edge_hit;
  logic     inc;
  logic     wrap;
  logic     pw_done;
  logic     flag_q;

  tmr_prescaler #(.STAGES(PRE_STAGES), .SEL_W(SEL_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .sel (ctl_q.psel),
    .tick(tick)
  );

  tmr_insync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (tmr_in),
    .pol     (ctl_q.pol),
    .act_now (act_now),
    .act_prev(act_prev),
    .edge_hit(edge_hit)
  );

  always_comb begin
    inc = 1'b0;
    if (ctl_q.run) begin
      unique case (ctl_q.mode)
        MODE_EVENT: inc = edge_hit;
        MODE_TIMER: inc = tick;
        MODE_PULSE: inc = tick & act_now;
        default:    inc = 1'b0;
      endcase
    end
  end

  assign pw_done = ctl_q.run && (ctl_q.mode == MODE_PULSE) && act_prev && !act_now;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc),
    .load_we (pre_we),
    .load_val(pre_wdata),
    .stopped (~ctl_q.run),
    .count   (count_o),
    .wrap    (wrap)
  );

  tmr_pfd #(.ENABLE(PFD_OPTION)) u_pfd (
    .clk(clk),
    .rst(rst),
    .wrap(wrap),
    .en (ctl_q.pfd_en),
    .pin(pfd_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we)       ctl_q     <= tmr_ctl_t'(ctl_wdata);
      else if (pw_done) ctl_q.run <= 1'b0;
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign run_o      = ctl_q.run;
  assign ovf_flag_o = flag_q;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_we,
  input logic             pre_we,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_o,
  input logic             run_o,
  input logic             ovf_flag_o,
  input logic             pfd_o,
  input logic             pfd_en,
  input logic [1:0]       mode
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3: the count only steps by one, or reloads from the top value
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pre_we) && count_o != $past(count_o))
      |-> (count_o == CNT_W'($past(count_o) + 1'b1) || $past(count_o) == TOP));

  // R3: leaving the top value without a write always raises the flag
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pre_we) && $past(count_o) == TOP && count_o != TOP)
      |-> ovf_flag_o);

  // R5: flag is sticky until cleared
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag_o && !flag_clr) |=> ovf_flag_o);

  // R8: divider pin only high when its enable was set
  assert_pfd_gate_R8: assert property (@(posedge clk) disable iff (rst)
    pfd_o |-> $past(pfd_en));

  // R7: run clears by itself only in pulse mode
  assert_self_stop_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(run_o) && !$past(ctl_we)) |-> ($past(mode) == 2'b11));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_we    (ctl_we),
  .pre_we    (pre_we),
  .flag_clr  (flag_clr),
  .count_o   (count_o),
  .run_o     (run_o),
  .ovf_flag_o(ovf_flag_o),
  .pfd_o     (pfd_o),
  .pfd_en    (ctl_q.pfd_en),
  .mode      (ctl_q.mode)
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       pre_we = 1'b0;
  logic [7:0] pre_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       tmr_in = 1'b0;
  logic [7:0] count_o;
  logic       run_o;
  logic       ovf_flag_o;
  logic       pfd_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  evt_timer u_evt_timer (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .pre_we(pre_we), .pre_wdata(pre_wdata), .flag_clr(flag_clr),
    .tmr_in(tmr_in), .count_o(count_o), .run_o(run_o),
    .ovf_flag_o(ovf_flag_o), .pfd_o(pfd_o)
  );

  // behavioural reference
  int   m_cnt, m_pre, m_ctl, cyc;
  bit   m_flag, m_tgl, m_pin;
  bit   hist[$];
  bit   model_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_ctl = 0; m_flag = 0; m_tgl = 0; m_pin = 0;
      cyc = 0; hist = '{0, 0, 0};
      model_live = 1;
    end else begin
      int  mode, sel, dv, nc;
      bit  run, pol, tick, a_now, a_prev, inc, endpw, wr;
      mode = m_ctl & 3; pol = m_ctl[2]; run = m_ctl[3];
      sel = (m_ctl >> 4) & 7; if (sel > 6) sel = 6;
      dv = 1 << (sel + 1);
      tick = ((cyc % dv) == dv - 1);
      a_now = hist[1] ^ pol; a_prev = hist[2] ^ pol;
      inc = 0;
      if (run) begin
        if (mode == 1) inc = a_now && !a_prev;
        if (mode == 2) inc = tick;
        if (mode == 3) inc = tick && a_now;
      end
      endpw = run && mode == 3 && a_prev && !a_now;
      m_pin = m_ctl[7] & m_tgl;
      wr = inc && m_cnt == 255;
      nc = m_cnt;
      if (pre_we && !run) nc = pre_wdata;
      else if (inc) nc = wr ? m_pre : m_cnt + 1;
      if (pre_we) m_pre = pre_wdata;
      m_cnt = nc;
      if (wr) begin m_flag = 1; m_tgl = ~m_tgl; end
      else if (flag_clr) m_flag = 0;
      if (ctl_we) m_ctl = ctl_wdata;
      else if (endpw) m_ctl = m_ctl & ~8'h08;
      cyc++;
      hist.push_front(tmr_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      vectors++;
      if (count_o != m_cnt[7:0]) begin fails++; $display("FAIL R3 count actual=%0h expected=%0h", count_o, m_cnt); end
      if (run_o != m_ctl[3])     begin fails++; $display("FAIL R7 run actual=%0b expected=%0b", run_o, m_ctl[3]); end
      if (ovf_flag_o != m_flag)  begin fails++; $display("FAIL R5 flag actual=%0b expected=%0b", ovf_flag_o, m_flag); end
      if (pfd_o != m_pin)        begin fails++; $display("FAIL R8 pfd actual=%0b expected=%0b", pfd_o, m_pin); end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1; ctl_wdata = d; @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_pre(input logic [7:0] d);
    pre_we = 1; pre_wdata = d; @(negedge clk); pre_we = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(input int hi, input int lo);
    tmr_in = 1; idle(hi); tmr_in = 0; idle(lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int saved;
    int k;
    idle(3); rst = 0; idle(1);
    // R1 reset state
    check("R1 count", count_o, 0); check("R1 flag", ovf_flag_o, 0);
    check("R1 run", run_o, 0);     check("R1 pfd", pfd_o, 0);

    // R4 load while stopped, R9 hold in idle mode with run set
    wr_pre(8'h10); idle(1);
    check("R4 stopped load", count_o, 8'h10);
    wr_ctl(8'h08); wr_pre(8'h55); idle(3);
    check("R4 running preload", count_o, 8'h10);
    check("R9 idle hold", count_o, 8'h10);

    // R3 overflow reload with divider enabled, timer /2
    wr_ctl(8'h8A);
    k = 0;
    while (!ovf_flag_o && k < 2000) begin idle(1); k++; end
    check("R3 reload", count_o, 8'h55);
    check("R3 flag", ovf_flag_o, 1);
    idle(2);
    check("R8 pin high", pfd_o, 1);
    flag_clr = 1; idle(1); flag_clr = 0;
    check("R5 cleared", ovf_flag_o, 0);
    wr_ctl(8'h00);

    // R2 prescale: select 7 clamps to /128, select 0 is /2
    wr_pre(8'h00); wr_ctl(8'h7A); idle(512);
    check("R2 div128", count_o, 4);
    wr_ctl(8'h00); wr_pre(8'h00); wr_ctl(8'h0A); idle(10);
    check("R2 div2", count_o, 5);

    // R6 event mode, rising then falling
    wr_ctl(8'h00); wr_pre(8'h00); wr_ctl(8'h09);
    for (int i = 0; i < 5; i++) pulse(3, 3);
    idle(4);
    check("R6 rising", count_o, 5);
    wr_ctl(8'h00); wr_pre(8'h00); wr_ctl(8'h0D);
    for (int i = 0; i < 3; i++) pulse(3, 3);
    idle(4);
    check("R6 falling", count_o, 3);

    // R7 one pulse measured, second ignored
    wr_ctl(8'h00); wr_pre(8'h00); wr_ctl(8'h0B); idle(3);
    pulse(20, 6);
    check("R7 stopped", run_o, 0);
    saved = count_o;
    check("R7 counted", (saved >= 8 && saved <= 11) ? 1 : 0, 1);
    pulse(20, 6);
    check("R7 held", count_o, saved);

    // R8 divider gated off
    wr_ctl(8'h00); wr_pre(8'hFE); wr_ctl(8'h0A); idle(20);
    check("R8 pin low", pfd_o, 0);
    check("R3 flag again", ovf_flag_o, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule